// File: doc/BRIEF.md
# Watermark-Driven Data FIFO with DMA Burst Requests

This block is the data buffer between a bus side (a CPU or a DMA engine) and a card data path. It flows one way at a time. In transmit mode the bus side fills it and the card side drains it. In receive mode the card side fills it and the bus side drains it. The block tracks its fill level and compares that level against two programmable 12-bit thresholds, one for each direction. From those comparisons it drives level interrupt flags and a DMA burst request.

A DMA request opens when the watermark for the active direction is met. It stays open until the engine has acknowledged as many words as the programmed burst length. The request then closes for one cycle, and the watermark is evaluated again. A push into a full buffer or a pop from an empty one is dropped and raises a sticky error flag. A one-cycle clear strobe empties the buffer, abandons any open burst, and raises a busy indication for exactly one cycle afterwards.

Top module: `wm_dma_fifo`

## Requirements
- R1: After reset, `fill_count` is 0, `empty` is 1, and `full`, `dma_req`, `xrun_err` and `clr_busy` are all 0.
- R2: Words pushed by the active producer are read back in push order, and `rd_data` always shows the oldest word. `fill_count` changes at the clock edge that captures a push or a pop. `full` is 1 exactly when the count equals the depth, and `empty` is 1 exactly when the count is 0.
- R3: With `tx_mode`=1, `bus_push` writes and `card_pop` reads. With `tx_mode`=0, `card_push` writes and `bus_pop` reads. Strobes from the inactive side have no effect on the count or the contents.
- R4: A push while full and a pop while empty are dropped, and the stored words and pointers stay unchanged. Either event sets `xrun_err` at the capturing edge. `xrun_err` then stays set until a clear.
- R5: `tx_wm_hit` is 1 when the fill count is at or below `tx_wm`. `rx_wm_hit` is 1 when the fill count is strictly above `rx_wm`. Both follow the count without further delay.
- R6: `tx_dreq_irq` equals `tx_wm_hit` while `tx_mode`=1 and is 0 otherwise. `rx_dreq_irq` equals `rx_wm_hit` while `tx_mode`=0 and is 0 otherwise.
- R7: The burst length is taken from `burst_code` when a burst opens. Code 0 gives 1 word, code 1 gives 4 words, code 2 gives 8 words, and every other code gives 1 word.
- R8: While no burst is open, `dma_req` rises at the edge after the active direction's watermark flag is seen high. It stays high until the edge that captures the last acknowledge of the burst, and it is low for at least the following cycle.
- R9: A `fifo_clr` strobe empties the buffer, clears `xrun_err` and closes any burst at its capturing edge. A push or pop in that same cycle is ignored. `clr_busy` is high for the single cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 1 | 1: bus to card, 0: card to bus |
| fifo_clr | input | 1 | One-cycle strobe that empties the buffer |
| bus_push | input | 1 | Bus-side write strobe |
| bus_wdata | input | DATA_W | Bus-side write data |
| bus_pop | input | 1 | Bus-side read strobe |
| card_push | input | 1 | Card-side write strobe |
| card_wdata | input | DATA_W | Card-side write data |
| card_pop | input | 1 | Card-side read strobe |
| rd_data | output | DATA_W | Oldest stored word |
| tx_wm | input | WM_W | Transmit threshold |
| rx_wm | input | WM_W | Receive threshold |
| burst_code | input | 3 | Burst length code |
| dma_ack | input | 1 | DMA word acknowledge |
| fill_count | output | WM_W+1 | Words held |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| tx_wm_hit | output | 1 | Transmit threshold met |
| rx_wm_hit | output | 1 | Receive threshold met |
| tx_dreq_irq | output | 1 | Transmit data-request interrupt |
| rx_dreq_irq | output | 1 | Receive data-request interrupt |
| dma_req | output | 1 | DMA burst request |
| xrun_err | output | 1 | Sticky overrun/underrun error |
| clr_busy | output | 1 | High for the cycle after a clear |

## Verification
Count, `full`, `empty`, `rd_data`, `xrun_err` and `clr_busy` each pass through one register. They are due one edge after the strobe that causes them. The watermark and interrupt flags are combinational from the count, so they are valid in the same cycle as the count. `dma_req` passes through two registers, the count and then the burst state, so it rises two edges after a push that meets the watermark. It falls one edge after the final acknowledge. The bench drives every input on the falling edge and samples on the next falling edge, one rising edge later. Where a result is due two edges later, the bench first checks that it has not yet moved, then checks it one cycle on. Direction changes are sampled after a short settle delay.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

    typedef enum logic {
        DMA_IDLE  = 1'b0,
        DMA_BURST = 1'b1
    } dma_state_t;

    localparam int BEAT_W = 4;

    typedef struct packed {
        logic tx_hit;
        logic rx_hit;
    } wm_flags_t;

    // Map the burst code to a word count; unknown codes fall back to one word.
    function automatic logic [BEAT_W-1:0] burst_beats(input logic [2:0] code);
        case (code)
            3'd1:    burst_beats = BEAT_W'(4);
            3'd2:    burst_beats = BEAT_W'(8);
            default: burst_beats = BEAT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/wmf_store.sv
module wmf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [AW:0]       count,
    output logic              full,
    output logic              empty,
    output logic              xrun
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              push_ok, pop_ok;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            xrun  <= 1'b0;
        end else begin
            if (push_ok) wptr <= wptr + AW'(1);
            if (pop_ok)  rptr <= rptr + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
            if ((push && full) || (pop && empty)) xrun <= 1'b1;
        end
    end

endmodule

// File: rtl/wmf_thresh.sv
module wmf_thresh #(
    parameter int WM_W = 12,
    localparam int CNT_W = WM_W + 1
) (
    input  logic             tx_mode,
    input  logic [CNT_W-1:0] count,
    input  logic [WM_W-1:0]  tx_wm,
    input  logic [WM_W-1:0]  rx_wm,
    output wmf_pkg::wm_flags_t flags,
    output logic             tx_irq,
    output logic             rx_irq,
    output logic             want
);

    assign flags.tx_hit = (count <= {1'b0, tx_wm});
    assign flags.rx_hit = (count >  {1'b0, rx_wm});
    assign tx_irq       = tx_mode && flags.tx_hit;
    assign rx_irq       = !tx_mode && flags.rx_hit;
    assign want         = tx_mode ? flags.tx_hit : flags.rx_hit;

endmodule

// File: rtl/wmf_dma.sv
module wmf_dma
    import wmf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       want,
    input  logic [2:0] burst_code,
    input  logic       ack,
    output logic       req
);

    dma_state_t        state;
    logic [BEAT_W-1:0] beats;
    logic [BEAT_W-1:0] blen;

    assign req = (state == DMA_BURST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= DMA_IDLE;
            beats <= '0;
            blen  <= BEAT_W'(1);
        end else begin
            case (state)
                DMA_IDLE: begin
                    if (want) begin
                        state <= DMA_BURST;
                        beats <= '0;
                        blen  <= burst_beats(burst_code);
                    end
                end
                DMA_BURST: begin
                    if (ack) begin
                        if (beats == blen - BEAT_W'(1)) begin
                            state <= DMA_IDLE;
                        end else begin
                            beats <= beats + BEAT_W'(1);
                        end
                    end
                end
                default: state <= DMA_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wm_dma_fifo.sv
module wm_dma_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int WM_W   = 12,
    localparam int CNT_W = WM_W + 1,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_mode,
    input  logic              fifo_clr,
    input  logic              bus_push,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_pop,
    input  logic              card_push,
    input  logic [DATA_W-1:0] card_wdata,
    input  logic              card_pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic [WM_W-1:0]   tx_wm,
    input  logic [WM_W-1:0]   rx_wm,
    input  logic [2:0]        burst_code,
    input  logic              dma_ack,
    output logic [CNT_W-1:0]  fill_count,
    output logic              full,
    output logic              empty,
    output logic              tx_wm_hit,
    output logic              rx_wm_hit,
    output logic              tx_dreq_irq,
    output logic              rx_dreq_irq,
    output logic              dma_req,
    output logic              xrun_err,
    output logic              clr_busy
);

    logic              push, pop, want;
    logic [DATA_W-1:0] wdata;
    logic [AW:0]       count;
    wmf_pkg::wm_flags_t flags;

    assign push  = tx_mode ? bus_push  : card_push;
    assign pop   = tx_mode ? card_pop  : bus_pop;
    assign wdata = tx_mode ? bus_wdata : card_wdata;

    assign fill_count = {{(CNT_W-AW-1){1'b0}}, count};
    assign tx_wm_hit  = flags.tx_hit;
    assign rx_wm_hit  = flags.rx_hit;

    always_ff @(posedge clk) begin
        if (rst) clr_busy <= 1'b0;
        else     clr_busy <= fifo_clr;
    end

    wmf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .clr(fifo_clr), .push(push), .pop(pop),
        .wdata(wdata), .rdata(rd_data), .count(count),
        .full(full), .empty(empty), .xrun(xrun_err)
    );

    wmf_thresh #(.WM_W(WM_W)) u_thresh (
        .tx_mode(tx_mode), .count(fill_count), .tx_wm(tx_wm), .rx_wm(rx_wm),
        .flags(flags), .tx_irq(tx_dreq_irq), .rx_irq(rx_dreq_irq), .want(want)
    );

    wmf_dma u_dma (
        .clk(clk), .rst(rst), .clr(fifo_clr), .want(want),
        .burst_code(burst_code), .ack(dma_ack), .req(dma_req)
    );

endmodule

// File: rtl/wmf_chk.sv
module wmf_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_mode,
    input logic             fifo_clr,
    input logic             bus_push,
    input logic             bus_pop,
    input logic             card_push,
    input logic             card_pop,
    input logic             dma_ack,
    input logic [CNT_W-1:0] fill_count,
    input logic             full,
    input logic             empty,
    input logic             dma_req,
    input logic             xrun_err,
    input logic             clr_busy
);

    logic push_act, pop_act;
    assign push_act = tx_mode ? bus_push : card_push;
    assign pop_act  = tx_mode ? card_pop : bus_pop;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R2
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_count <= CNT_W'(DEPTH)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && push_act && !pop_act && !fifo_clr) |=> (full && fill_count == $past(fill_count))); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_act && !push_act && !fifo_clr) |=> empty); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (xrun_err && !fifo_clr) |=> xrun_err); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_ack && !fifo_clr) |=> dma_req); // R8
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (empty && !xrun_err && clr_busy && !dma_req)); // R9
    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (clr_busy && !fifo_clr) |=> !clr_busy); // R9

endmodule

bind wm_dma_fifo wmf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_wmf_chk (
    .clk(clk), .rst(rst), .tx_mode(tx_mode), .fifo_clr(fifo_clr),
    .bus_push(bus_push), .bus_pop(bus_pop), .card_push(card_push), .card_pop(card_pop),
    .dma_ack(dma_ack), .fill_count(fill_count), .full(full), .empty(empty),
    .dma_req(dma_req), .xrun_err(xrun_err), .clr_busy(clr_busy)
);

// File: tb/test_wm_dma_fifo.sv
module test_wm_dma_fifo;

    localparam int DW = 32;
    localparam int D  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx_mode = 1'b1, fifo_clr = 1'b0;
    logic          bus_push = 1'b0, bus_pop = 1'b0, card_push = 1'b0, card_pop = 1'b0;
    logic [DW-1:0] bus_wdata = '0, card_wdata = '0, rd_data;
    logic [11:0]   tx_wm = '0, rx_wm = '0;
    logic [2:0]    burst_code = '0;
    logic          dma_ack = 1'b0;
    logic [12:0]   fill_count;
    logic          full, empty, tx_wm_hit, rx_wm_hit, tx_dreq_irq, rx_dreq_irq;
    logic          dma_req, xrun_err, clr_busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wm_dma_fifo #(.DATA_W(DW), .DEPTH(D), .WM_W(12)) i_wm_dma_fifo (
        .clk(clk), .rst(rst), .tx_mode(tx_mode), .fifo_clr(fifo_clr),
        .bus_push(bus_push), .bus_wdata(bus_wdata), .bus_pop(bus_pop),
        .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
        .rd_data(rd_data), .tx_wm(tx_wm), .rx_wm(rx_wm), .burst_code(burst_code),
        .dma_ack(dma_ack), .fill_count(fill_count), .full(full), .empty(empty),
        .tx_wm_hit(tx_wm_hit), .rx_wm_hit(rx_wm_hit), .tx_dreq_irq(tx_dreq_irq),
        .rx_dreq_irq(rx_dreq_irq), .dma_req(dma_req), .xrun_err(xrun_err),
        .clr_busy(clr_busy)
    );

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push_w(input logic [DW-1:0] d);
        if (tx_mode) begin bus_push = 1'b1; bus_wdata = d; end
        else begin card_push = 1'b1; card_wdata = d; end
        tick();
        bus_push = 1'b0; card_push = 1'b0;
    endtask

    task automatic pop_w();
        if (tx_mode) card_pop = 1'b1; else bus_pop = 1'b1;
        tick();
        card_pop = 1'b0; bus_pop = 1'b0;
    endtask

    task automatic clr_w();
        fifo_clr = 1'b1;
        tick();
        fifo_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "count", 64'(fill_count), 0);
        chk("R1", "empty", 64'(empty), 1);
        chk("R1", "full", 64'(full), 0);
        chk("R1", "dma_req", 64'(dma_req), 0);
        chk("R1", "xrun_err", 64'(xrun_err), 0);
        chk("R1", "clr_busy", 64'(clr_busy), 0);
    endtask

    task automatic t_order();
        tx_mode = 1'b1;
        clr_w();
        push_w(32'hA1); push_w(32'hB2); push_w(32'hC3);
        chk("R2", "count after 3 pushes", 64'(fill_count), 3);
        chk("R2", "head word", 64'(rd_data), 64'hA1);
        bus_pop = 1'b1; tick(); bus_pop = 1'b0;
        chk("R3", "inactive pop count", 64'(fill_count), 3);
        card_push = 1'b1; card_wdata = 32'h99; tick(); card_push = 1'b0;
        chk("R3", "inactive push count", 64'(fill_count), 3);
        pop_w();
        chk("R2", "second word", 64'(rd_data), 64'hB2);
        chk("R2", "count after pop", 64'(fill_count), 2);
        pop_w();
        chk("R3", "third word, card push absent", 64'(rd_data), 64'hC3);
        pop_w();
        chk("R2", "empty after drain", 64'(empty), 1);
    endtask

    task automatic t_full();
        tx_mode = 1'b1;
        clr_w();
        for (int i = 0; i < D; i++) push_w(DW'(i * 3 + 1));
        chk("R2", "full flag", 64'(full), 1);
        chk("R2", "full count", 64'(fill_count), D);
        push_w(32'hDEAD);
        chk("R4", "count after overflow", 64'(fill_count), D);
        chk("R4", "error after overflow", 64'(xrun_err), 1);
        for (int i = 0; i < D; i++) begin
            chk("R4", "word kept through overflow", 64'(rd_data), 64'(i * 3 + 1));
            pop_w();
        end
        chk("R2", "empty after full drain", 64'(empty), 1);
        pop_w();
        chk("R4", "count after underflow", 64'(fill_count), 0);
        push_w(32'h77);
        chk("R4", "pointer intact after underflow", 64'(rd_data), 64'h77);
        chk("R4", "count after push", 64'(fill_count), 1);
        chk("R4", "error sticky", 64'(xrun_err), 1);
    endtask

    task automatic t_clear();
        fifo_clr = 1'b1; bus_push = 1'b1; bus_wdata = 32'h55;
        tick();
        fifo_clr = 1'b0; bus_push = 1'b0;
        chk("R9", "count after clear", 64'(fill_count), 0);
        chk("R9", "error after clear", 64'(xrun_err), 0);
        chk("R9", "busy after clear", 64'(clr_busy), 1);
        tick();
        chk("R9", "busy one cycle", 64'(clr_busy), 0);
        chk("R9", "push in clear cycle dropped", 64'(empty), 1);
    endtask

    task automatic t_wm();
        tx_mode = 1'b1; tx_wm = 12'd2; rx_wm = 12'd1;
        clr_w();
        chk("R5", "tx hit at 0", 64'(tx_wm_hit), 1);
        chk("R5", "rx hit at 0", 64'(rx_wm_hit), 0);
        chk("R6", "tx irq tx mode", 64'(tx_dreq_irq), 1);
        chk("R6", "rx irq tx mode", 64'(rx_dreq_irq), 0);
        push_w(32'h1); push_w(32'h2);
        chk("R5", "tx hit at equal", 64'(tx_wm_hit), 1);
        chk("R5", "rx hit above", 64'(rx_wm_hit), 1);
        chk("R6", "rx irq gated in tx mode", 64'(rx_dreq_irq), 0);
        push_w(32'h3);
        chk("R5", "tx hit above", 64'(tx_wm_hit), 0);
        chk("R6", "tx irq above", 64'(tx_dreq_irq), 0);
        tx_mode = 1'b0; #1;
        chk("R6", "rx irq rx mode", 64'(rx_dreq_irq), 1);
        chk("R6", "tx irq rx mode", 64'(tx_dreq_irq), 0);
        rx_wm = 12'd3; #1;
        chk("R5", "rx hit at equal", 64'(rx_wm_hit), 0);
        tick();
    endtask

    task automatic t_burst(input logic [2:0] code, input int len);
        tx_mode = 1'b1; tx_wm = 12'd4; burst_code = code;
        clr_w();
        chk("R9", "req closed by clear", 64'(dma_req), 0);
        tick();
        chk("R8", "req opens", 64'(dma_req), 1);
        dma_ack = 1'b1;
        for (int i = 0; i < len - 1; i++) begin
            tick();
            chk("R7", "req held mid burst", 64'(dma_req), 1);
        end
        tick();
        dma_ack = 1'b0;
        chk("R7", "req drops at burst end", 64'(dma_req), 0);
        tick();
        chk("R8", "req reopens", 64'(dma_req), 1);
    endtask

    task automatic t_rx_req();
        tx_mode = 1'b0; rx_wm = 12'd0;
        clr_w();
        repeat (3) tick();
        chk("R8", "no req below rx wm", 64'(dma_req), 0);
        push_w(32'hE1);
        chk("R8", "req not yet after push", 64'(dma_req), 0);
        tick();
        chk("R8", "req after rx wm met", 64'(dma_req), 1);
        clr_w();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_order();
        t_full();
        t_clear();
        t_wm();
        t_burst(3'd0, 1);
        t_burst(3'd1, 4);
        t_burst(3'd2, 8);
        t_burst(3'd6, 1);
        t_rx_req();
        summary();
        $finish;
    end

endmodule